// File: doc/BRIEF.md
# Wrapping Burst Read Address Sequencer

This block sits behind the command decoder of a serial flash read path. It holds an 8-bit volatile settings byte. The byte sets three things: how many dummy clocks follow a fast-read command, an active-low execute-in-place control, and how the byte address moves during the burst. The burst address either wraps inside an aligned 16, 32 or 64 byte window, or runs through the whole 24-bit array.

A burst begins with a one-cycle `burst_start_i` pulse that carries the start address. The block then counts the configured number of dummy clocks and raises `data_phase_o`. After that, every `advance_i` strobe steps `addr_o` to the next byte of the sequence. The settings in force are latched when the burst starts. A register write made during a burst therefore governs only the following burst.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted, `cfg_rdata_o` reads 0xFB, `addr_o` is 0, `data_phase_o` is 0 and `xip_en_o` is 0.
- R2: A write with `cfg_we_i` high is visible on `cfg_rdata_o` after the next clock edge. The layout is: dummy code in bits 7:4, execute-in-place control in bit 3, reserved in bit 2, wrap mode in bits 1:0.
- R3: Bit 2 of `cfg_rdata_o` always reads 0, whatever value is written to it.
- R4: For a dummy code N from 1 to 14, `data_phase_o` is low after the clock edge that samples `burst_start_i`. It rises exactly N edges after that edge.
- R5: Dummy codes 0 and 15 both give 10 dummy clocks.
- R6: During the dummy phase, `addr_o` holds the start address and `advance_i` has no effect. Once `data_phase_o` is high it stays high until the next `burst_start_i`.
- R7: Wrap codes 0, 1 and 2 make the address wrap inside an aligned 16, 32 or 64 byte window. The sequence begins at any offset in the window. Bits above the window never change.
- R8: Wrap code 3 (the reset value) increments the full 24-bit address and rolls 0xFFFFFF over to 0x000000.
- R9: `xip_en_o` is 1 exactly when bit 3 of the settings byte is 0.
- R10: Dummy code and wrap mode are taken from the register as it stood before the `burst_start_i` edge. A write during a burst, or in the same cycle as `burst_start_i`, applies only to the next burst.
- R11: A `burst_start_i` during a burst restarts the burst: it loads the new address and starts a full new dummy phase.
- R12: In the data phase, each edge with `advance_i` high moves `addr_o` one step. Without `advance_i`, `addr_o` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Settings byte write enable |
| cfg_wdata_i | input | 8 | Settings byte write data |
| cfg_rdata_o | output | 8 | Settings byte readback |
| xip_en_o | output | 1 | Execute-in-place enabled |
| burst_start_i | input | 1 | One-cycle burst start pulse |
| start_addr_i | input | 24 | Burst start byte address |
| advance_i | input | 1 | Data-advance strobe |
| data_phase_o | output | 1 | Dummy clocks done, data phase active |
| addr_o | output | 24 | Current byte address |

## Verification
The checker relies on `burst_start_i` and `advance_i` being sampled only at clock edges. It also relies on a restart being the only way to leave the data phase. The checker makes no assumption about how long `advance_i` stays high or low. The stimulus drives every input one nanosecond after the rising edge and holds it for a full cycle. It keeps `advance_i` high through whole dummy phases so that the ignore rule is exercised. Settings writes are placed only in the positions the requirements define: between bursts, inside a data phase, and in the same cycle as a start.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  typedef enum logic [1:0] {
    WRAP_16   = 2'b00,
    WRAP_32   = 2'b01,
    WRAP_64   = 2'b10,
    WRAP_CONT = 2'b11
  } wrap_mode_e;

  typedef struct packed {
    logic [3:0] dummy;
    logic       xip_n;
    logic       rsvd;
    wrap_mode_e wrap;
  } vcfg_t;

  localparam vcfg_t VCFG_RESET = '{dummy: 4'hF, xip_n: 1'b1, rsvd: 1'b0, wrap: WRAP_CONT};
  localparam int unsigned WIN_LG_MIN = 4;

endpackage

// File: rtl/bsq_cfg_reg.sv
module bsq_cfg_reg
  import burst_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  output vcfg_t      cfg_o
);

  vcfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= VCFG_RESET;
    end else if (we_i) begin
      cfg_q <= '{dummy: wdata_i[7:4], xip_n: wdata_i[3], rsvd: 1'b0,
                 wrap: wrap_mode_e'(wdata_i[1:0])};
    end
  end

  assign cfg_o = cfg_q;

endmodule

// File: rtl/bsq_dummy_ctr.sv
module bsq_dummy_ctr #(
  parameter int unsigned CODE_W     = 4,
  parameter int unsigned DFLT_DUMMY = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              done_o
);

  localparam logic [CODE_W-1:0] CODE_ALL1 = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] DFLT_N    = CODE_W'(DFLT_DUMMY);

  logic [CODE_W-1:0] cnt_q;
  logic [CODE_W-1:0] load_n;
  logic              busy_q;
  logic              done_q;

  // 0 and all-ones both select the default count
  always_comb begin
    if (code_i == '0 || code_i == CODE_ALL1) load_n = DFLT_N;
    else                                     load_n = code_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= load_n;
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CODE_W'(1)) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  assign done_o = done_q;

endmodule

// File: rtl/bsq_addr_gen.sv
module bsq_addr_gen
  import burst_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic              step_i,
  input  wrap_mode_e        mode_i,
  output logic [ADDR_W-1:0] addr_o
);

  localparam int unsigned NWIN = 3;

  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] inc;
  logic [ADDR_W-1:0] nxt;
  logic [ADDR_W-1:0] win_mask [NWIN];

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    localparam int unsigned LG = WIN_LG_MIN + g;
    assign win_mask[g] = (ADDR_W'(1) << LG) - ADDR_W'(1);
  end

  assign inc = addr_q + ADDR_W'(1);

  always_comb begin
    if (mode_i == WRAP_CONT) nxt = inc;
    else nxt = (addr_q & ~win_mask[mode_i]) | (inc & win_mask[mode_i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      addr_q <= '0;
    else if (load_i)  addr_q <= load_addr_i;
    else if (step_i)  addr_q <= nxt;
  end

  assign addr_o = addr_q;

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int unsigned ADDR_W     = 24,
  parameter int unsigned DFLT_DUMMY = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [7:0]        cfg_wdata_i,
  output logic [7:0]        cfg_rdata_o,
  output logic              xip_en_o,
  input  logic              burst_start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              advance_i,
  output logic              data_phase_o,
  output logic [ADDR_W-1:0] addr_o
);

  vcfg_t      cfg;
  wrap_mode_e act_wrap_q;
  logic       done;
  logic       step;

  bsq_cfg_reg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg)
  );

  // burst settings latched at start; later writes wait for next burst
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            act_wrap_q <= WRAP_CONT;
    else if (burst_start_i) act_wrap_q <= cfg.wrap;
  end

  bsq_dummy_ctr #(
    .CODE_W     (4),
    .DFLT_DUMMY (DFLT_DUMMY)
  ) u_dummy (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (burst_start_i),
    .code_i  (cfg.dummy),
    .done_o  (done)
  );

  assign step = advance_i & done & ~burst_start_i;

  bsq_addr_gen #(
    .ADDR_W (ADDR_W)
  ) u_addr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (burst_start_i),
    .load_addr_i (start_addr_i),
    .step_i      (step),
    .mode_i      (act_wrap_q),
    .addr_o      (addr_o)
  );

  assign cfg_rdata_o  = cfg;
  assign xip_en_o     = ~cfg.xip_n;
  assign data_phase_o = done;

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int unsigned ADDR_W = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              burst_start_i,
  input logic [ADDR_W-1:0] start_addr_i,
  input logic              advance_i,
  input logic              data_phase_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic [7:0]        cfg_rdata_o
);

  logic [4:0] since_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               since_q <= 5'd31;
    else if (burst_start_i)    since_q <= 5'd0;
    else if (since_q != 5'd31) since_q <= since_q + 5'd1;
  end

  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_rdata_o[2] == 1'b0); // R3
  AST_DUMMY_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(data_phase_o) |-> (since_q >= 5'd1 && since_q <= 5'd14)); // R4
  AST_START_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_start_i |=> (!data_phase_o && addr_o == $past(start_addr_i))); // R11
  AST_DUMMY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!data_phase_o && !burst_start_i) |=> $stable(addr_o)); // R6
  AST_PHASE_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_phase_o && !burst_start_i) |=> data_phase_o); // R6
  AST_LOW_NIBBLE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_phase_o && advance_i && !burst_start_i) |=>
      addr_o[3:0] == $past(addr_o[3:0]) + 4'd1); // R7
  AST_HOLD_NO_ADV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_phase_o && !advance_i && !burst_start_i) |=> $stable(addr_o)); // R12

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .burst_start_i (burst_start_i),
  .start_addr_i  (start_addr_i),
  .advance_i     (advance_i),
  .data_phase_o  (data_phase_o),
  .addr_o        (addr_o),
  .cfg_rdata_o   (cfg_rdata_o)
);

// File: tb/burst_addr_seq_tb_top.sv
`timescale 1ns/1ps
module burst_addr_seq_tb_top;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [7:0]  cfg_wdata_i = '0;
  logic [7:0]  cfg_rdata_o;
  logic        xip_en_o;
  logic        burst_start_i = 1'b0;
  logic [23:0] start_addr_i = '0;
  logic        advance_i = 1'b0;
  logic        data_phase_o;
  logic [23:0] addr_o;

  int checks = 0;
  int failures = 0;
  bit done_flag = 1'b0;

  always #2.5 clk_i = ~clk_i;

  burst_addr_seq dut_i (.*);

  // {wdata, readback, start, n_adv, dummy, final_addr}
  localparam int NV = 8;
  localparam logic [75:0] VEC [NV] = '{
    {8'h13, 8'h13, 24'h000010, 8'd5,  4'd1,  24'h000015},
    {8'hF0, 8'hF0, 24'h123405, 8'd12, 4'd10, 24'h123401},
    {8'h01, 8'h01, 24'h00000F, 8'd20, 4'd10, 24'h000003},
    {8'hE2, 8'hE2, 24'hABCDFF, 8'd1,  4'd14, 24'hABCDC0},
    {8'h53, 8'h53, 24'hFFFFFE, 8'd3,  4'd5,  24'h000001},
    {8'h21, 8'h21, 24'h7700E0, 8'd32, 4'd2,  24'h7700E0},
    {8'h70, 8'h70, 24'h00000F, 8'd1,  4'd7,  24'h000000},
    {8'h36, 8'h32, 24'h000100, 8'd70, 4'd3,  24'h000106}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic wr_cfg(input logic [7:0] v);
    cfg_we_i = 1'b1;
    cfg_wdata_i = v;
    tick();
    cfg_we_i = 1'b0;
  endtask

  // starts a burst, holds advance high through the dummy phase, returns dummy count
  task automatic start_wait(input logic [23:0] a, output int n);
    burst_start_i = 1'b1;
    start_addr_i = a;
    tick();
    burst_start_i = 1'b0;
    cfg_we_i = 1'b0;
    advance_i = 1'b1;
    n = 0;
    while (!data_phase_o && n < 20) begin
      if (addr_o !== a) chk(1'b0, "R6 dummy addr hold", addr_o, a);
      tick();
      n++;
    end
    advance_i = 1'b0;
    chk(addr_o === a, "R6 addr at data start", addr_o, a);
  endtask

  task automatic adv(input int k);
    advance_i = 1'b1;
    repeat (k) tick();
    advance_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int n;
    #3;
    chk(cfg_rdata_o === 8'hFB, "R1 cfg reset", cfg_rdata_o, 8'hFB);
    chk(addr_o === 24'h0, "R1 addr reset", addr_o, 0);
    chk(data_phase_o === 1'b0, "R1 phase reset", data_phase_o, 0);
    chk(xip_en_o === 1'b0, "R1 xip reset", xip_en_o, 0);
    repeat (3) tick();
    rst_ni = 1'b1;
    tick();

    for (int i = 0; i < NV; i++) begin
      logic [75:0] v;
      v = VEC[i];
      wr_cfg(v[75:68]);
      chk(cfg_rdata_o === v[67:60], "R2 R3 readback", cfg_rdata_o, v[67:60]);
      chk(xip_en_o === ~v[71], "R9 xip", xip_en_o, ~v[71]);
      start_wait(v[59:36], n);
      chk(n == int'(v[27:24]), "R4 R5 dummy count", n, v[27:24]);
      adv(int'(v[35:28]));
      chk(addr_o === v[23:0], "R7 R8 final addr", addr_o, v[23:0]);
      repeat (2) tick();
      chk(addr_o === v[23:0], "R12 hold", addr_o, v[23:0]);
      chk(data_phase_o === 1'b1, "R6 phase stays", data_phase_o, 1);
    end

    // R10: write inside a data phase does not change the running burst
    wr_cfg(8'h13);
    start_wait(24'h00001E, n);
    wr_cfg(8'h10);
    adv(3);
    chk(addr_o === 24'h000021, "R10 mid-burst write", addr_o, 24'h000021);
    start_wait(24'h00001E, n);
    chk(n == 1, "R10 next dummy", n, 1);
    adv(3);
    chk(addr_o === 24'h000011, "R10 next wrap16", addr_o, 24'h000011);

    // R10: write in the start cycle applies to the following burst
    cfg_we_i = 1'b1;
    cfg_wdata_i = 8'h50;
    start_wait(24'h000040, n);
    chk(n == 1, "R10 same-cycle old dummy", n, 1);
    start_wait(24'h000040, n);
    chk(n == 5, "R10 same-cycle next dummy", n, 5);

    // R11: restart in the middle of a dummy phase
    burst_start_i = 1'b1;
    start_addr_i = 24'h000100;
    tick();
    burst_start_i = 1'b0;
    repeat (2) tick();
    start_wait(24'h000200, n);
    chk(n == 5, "R11 restart dummy", n, 5);
    chk(addr_o === 24'h000200, "R11 restart addr", addr_o, 24'h000200);

    // R11: restart from data phase drops data_phase at once
    burst_start_i = 1'b1;
    start_addr_i = 24'h000300;
    tick();
    burst_start_i = 1'b0;
    chk(data_phase_o === 1'b0, "R11 phase cleared", data_phase_o, 0);
    chk(addr_o === 24'h000300, "R11 new addr", addr_o, 24'h000300);

    finish_run();
  end

endmodule